// File: doc/BRIEF.md
# Dual-Protocol Two-Wire Serial Master

This block is a master for a shared two-wire serial bus made of a clock line and a data line, both open-drain. The host first writes a small configuration word that picks one of two framings and a clock divider. It then issues read or write commands. One framing is a management frame: a run of ones, a start code, an opcode, a 10-bit address split into a 5-bit device field and a 5-bit register field, a turnaround and 16 data bits. The other framing is a slow byte protocol. It opens with a start condition, sends three bytes, each followed by an acknowledge slot, and closes with a stop condition.

The block never drives a line high. Each line has an enable that pulls it low, and the bus pull-ups take it high. The block samples the data line to read returned bits, to see missing acknowledges and to spot a conflict on the wired-AND. A protocol-indicator pin shows which framing is running. The host watches `busy` and `done` and then reads `rdData`, `ackErr` and `lineClash`.

Top module: `dual_serial_master`

## Requirements
- R1: A pulse on `cfgWrite` stores `cfgLowSpeed` and `cfgDivider`, and the next transfer uses them. While `busy` is high, `protoInd` is 0 for a management transfer and 1 for a byte-protocol transfer. While idle, `protoInd` is 1.
- R2: Each bit period lasts 4*(D+1) system clocks, where D is the stored divider. The clock line is pulled low for the first half of each bit and released for the second half, so rising edges of the clock line are exactly 4*(D+1) cycles apart within a transfer.
- R3: A management transfer sends PRE_LEN ones, then 01, then the opcode (01 for write, 10 for read), then the device field and the register field (5 bits each, MSB first), then the turnaround (10 for write, released for read), then 16 data bits MSB first. The write data is `cmdWdata`. On a read, the data bits are released.
- R4: On a management read, the 16 data-line values sampled during the data bits are stored MSB first in `rdData`. A write leaves `rdData` at 0.
- R5: A byte-protocol transfer begins with a start condition and then sends three bytes, MSB first, each followed by one acknowledge slot. The bytes are the address byte {device, 00, read flag}, the register byte {000, register} and the data byte (`cmdWdata[7:0]` on a write, released on a read). The transfer ends with a stop condition.
- R6: On a byte-protocol read, the 8 sampled data bits go to `rdData[7:0]` and `rdData[15:8]` is 0. The master leaves the last acknowledge slot released.
- R7: If the data line reads high in an acknowledge slot that the slave must answer (both slots on a read, all three on a write), `ackErr` becomes 1. It holds until the next transfer starts, and the start clears it.
- R8: If the master releases the data line in a slot it owns and samples it low, `lineClash` becomes 1. Slots the master owns are all slots except acknowledge slots and, on reads, the turnaround and the returned data. `lineClash` holds until the next start.
- R9: `busy` rises in the cycle after an accepted `cmdStart` and stays high for the whole transfer. `done` is high for exactly one cycle, in the cycle where `busy` falls. A `cmdStart` while busy has no effect.
- R10: While idle, both line enables are off. A byte-protocol transfer shows exactly one start condition and one stop condition. During data bits, the data line changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | Store configuration strobe |
| cfgLowSpeed | input | 1 | Protocol select: 1 byte protocol, 0 management |
| cfgDivider | input | DIV_W | Divider D, bit period 4*(D+1) clocks |
| cmdStart | input | 1 | Start a transfer when idle |
| cmdRead | input | 1 | 1 read, 0 write |
| cmdDev | input | 5 | Device field |
| cmdReg | input | 5 | Register field |
| cmdWdata | input | 16 | Write data (low byte in byte protocol) |
| sdaIn | input | 1 | Sampled data line level |
| sclOe | output | 1 | Pull clock line low |
| sdaOe | output | 1 | Pull data line low |
| protoInd | output | 1 | Protocol indicator |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdData | output | 16 | Captured read data |
| ackErr | output | 1 | Missing acknowledge seen |
| lineClash | output | 1 | Conflict on the data line seen |

## Verification
The bench builds the block with PRE_LEN at 32, so every management frame is 64 bits, and with DIV_W at 4. The small DIV_W keeps bit periods short enough to sweep dividers 0 to 3 over full frames. It also allows all eight patterns of missing acknowledges in the byte protocol, several read-data patterns in both framings, and forced conflicts where the master releases the line. An open-drain slave model in the bench drives the shared lines and decodes them, so every framing fact is checked on the wired lines themselves.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_START, SEQ_BITS, SEQ_STOP, SEQ_FINISH
  } seqState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sampleData;
    logic sampleAck;
    logic checkClash;
  } seqStrobe_t;

  localparam int DEV_W    = 5;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int MD_TAIL  = 32;  // start, op, address, turnaround, data
  localparam int LS_BITS  = 27;  // three bytes with acknowledge slots
  localparam int LS_ACK_A = 8;
  localparam int LS_ACK_B = 17;
  localparam int LS_DAT_0 = 18;
  localparam int LS_DAT_7 = 25;
endpackage

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic                 cfgLowSpeed,
  input  logic [DIV_W-1:0]     cfgDivider,
  input  logic                 cmdRead,
  input  logic [DEV_W-1:0]     cmdDev,
  input  logic [REG_W-1:0]     cmdReg,
  input  logic [DATA_W-1:0]    cmdWdata,
  input  seqStrobe_t           strobe,
  input  logic                 sdaIn,
  output logic                 cfgLs,
  output logic                 tick,
  output logic                 txBit,
  output logic [DATA_W-1:0]    rdData,
  output logic                 ackErr,
  output logic                 lineClash
);
  localparam int FW = PRE_LEN + MD_TAIL;

  logic [DIV_W-1:0] cfgDiv, divActive, divCnt;
  logic [FW-1:0]    shReg, mdFrame, lsFrame;

  assign tick  = (divCnt == divActive);
  assign txBit = shReg[FW-1];

  // both framings share one shift register; a 1 means "release the line"
  assign mdFrame = {{PRE_LEN{1'b1}}, 2'b01, cmdRead ? 2'b10 : 2'b01, cmdDev, cmdReg,
                    cmdRead ? 2'b11 : 2'b10, cmdRead ? {DATA_W{1'b1}} : cmdWdata};
  assign lsFrame = {cmdDev, 2'b00, cmdRead, 1'b1, 3'b000, cmdReg, 1'b1,
                    cmdRead ? 8'hFF : cmdWdata[7:0], 1'b1, {(FW-LS_BITS){1'b1}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLs     <= 1'b0;
      cfgDiv    <= '0;
      divActive <= '0;
      divCnt    <= '0;
      shReg     <= '1;
      rdData    <= '0;
      ackErr    <= 1'b0;
      lineClash <= 1'b0;
    end else begin
      if (cfgWrite) begin
        cfgLs  <= cfgLowSpeed;
        cfgDiv <= cfgDivider;
      end
      if (strobe.load || tick) divCnt <= '0;
      else                     divCnt <= divCnt + 1'b1;
      if (strobe.load) begin
        divActive <= cfgDiv;
        shReg     <= cfgLs ? lsFrame : mdFrame;
        rdData    <= '0;
        ackErr    <= 1'b0;
        lineClash <= 1'b0;
      end else begin
        if (strobe.shift)      shReg  <= {shReg[FW-2:0], 1'b1};
        if (strobe.sampleData) rdData <= {rdData[DATA_W-2:0], sdaIn};
        if (strobe.sampleAck && sdaIn) ackErr <= 1'b1;
        if (strobe.checkClash && txBit && !sdaIn) lineClash <= 1'b1;
      end
    end
  end

  AST_SHIFT_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> tick);  // R2
  AST_ONE_SAMPLE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.sampleData, strobe.sampleAck, strobe.checkClash}) <= 1);  // R8
  AST_ACK_CLEARED_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !ackErr && !lineClash);  // R7
endmodule

// File: rtl/dsm_control.sv
module dsm_control
  import dsm_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdRead,
  input  logic       cfgLs,
  input  logic       tick,
  input  logic       txBit,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       modeLs,
  output logic       sclOe,
  output logic       sdaOe
);
  localparam int FW    = PRE_LEN + MD_TAIL;
  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [CNT_W-1:0] MD_LAST = CNT_W'(FW - 1);
  localparam logic [CNT_W-1:0] MD_DAT0 = CNT_W'(FW - DATA_W);
  localparam logic [CNT_W-1:0] MD_TA0  = CNT_W'(FW - DATA_W - 2);
  localparam logic [CNT_W-1:0] LS_LAST = CNT_W'(LS_BITS - 1);
  localparam logic [CNT_W-1:0] LS_A    = CNT_W'(LS_ACK_A);
  localparam logic [CNT_W-1:0] LS_B    = CNT_W'(LS_ACK_B);
  localparam logic [CNT_W-1:0] LS_D0   = CNT_W'(LS_DAT_0);
  localparam logic [CNT_W-1:0] LS_D7   = CNT_W'(LS_DAT_7);

  seqState_t        state;
  logic [1:0]       phase;
  logic [CNT_W-1:0] bitCnt;
  logic             rdMode, sdaHold;
  logic             lsData, ackSlot, relZone, sampleEdge;

  assign busy = (state != SEQ_IDLE);

  always_comb begin
    lsData     = (bitCnt >= LS_D0) && (bitCnt <= LS_D7);
    ackSlot    = modeLs && ((bitCnt == LS_A) || (bitCnt == LS_B) ||
                            ((bitCnt == LS_LAST) && !rdMode));
    relZone    = rdMode && (modeLs ? lsData : (bitCnt >= MD_TA0));
    sampleEdge = (state == SEQ_BITS) && tick && (phase == 2'd2);
    strobe.load       = (state == SEQ_IDLE) && cmdStart;
    strobe.shift      = (state == SEQ_BITS) && tick && (phase == 2'd3);
    strobe.sampleData = sampleEdge && rdMode && (modeLs ? lsData : (bitCnt >= MD_DAT0));
    strobe.sampleAck  = sampleEdge && ackSlot;
    strobe.checkClash = sampleEdge && !ackSlot && !relZone;
  end

  always_comb begin
    unique case (state)
      SEQ_START: begin sclOe = 1'b0;         sdaOe = phase[1]; end
      SEQ_BITS:  begin sclOe = !phase[1];    sdaOe = sdaHold; end
      SEQ_STOP:  begin sclOe = !phase[1];
                       sdaOe = (phase == 2'd0) ? sdaHold : (phase != 2'd3); end
      default:   begin sclOe = 1'b0;         sdaOe = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      phase   <= '0;
      bitCnt  <= '0;
      rdMode  <= 1'b0;
      modeLs  <= 1'b1;
      sdaHold <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (cmdStart) begin
          modeLs  <= cfgLs;
          rdMode  <= cmdRead;
          phase   <= '0;
          bitCnt  <= '0;
          sdaHold <= cfgLs;
          state   <= cfgLs ? SEQ_START : SEQ_BITS;
        end
        SEQ_START: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) state <= SEQ_BITS;
        end
        SEQ_BITS: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd0) sdaHold <= !txBit;
          if (phase == 2'd3) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == (modeLs ? LS_LAST : MD_LAST))
              state <= modeLs ? SEQ_STOP : SEQ_FINISH;
          end
        end
        SEQ_STOP: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) state <= SEQ_FINISH;
        end
        default: begin
          state <= SEQ_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(modeLs));  // R1
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_BITS && $past(state) == SEQ_BITS && !$stable(sdaOe)) |-> sclOe);  // R10
endmodule

// File: rtl/dual_serial_master.sv
module dual_serial_master
  import dsm_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic              cfgLowSpeed,
  input  logic [DIV_W-1:0]  cfgDivider,
  input  logic              cmdStart,
  input  logic              cmdRead,
  input  logic [4:0]        cmdDev,
  input  logic [4:0]        cmdReg,
  input  logic [15:0]       cmdWdata,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              protoInd,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdData,
  output logic              ackErr,
  output logic              lineClash
);
  seqStrobe_t strobe;
  logic cfgLs, tick, txBit, modeLs;

  dsm_control #(.PRE_LEN(PRE_LEN)) uCtl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cfgLs(cfgLs), .tick(tick), .txBit(txBit), .strobe(strobe),
    .busy(busy), .done(done), .modeLs(modeLs), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  dsm_datapath #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgLowSpeed(cfgLowSpeed),
    .cfgDivider(cfgDivider), .cmdRead(cmdRead), .cmdDev(cmdDev), .cmdReg(cmdReg),
    .cmdWdata(cmdWdata), .strobe(strobe), .sdaIn(sdaIn), .cfgLs(cfgLs),
    .tick(tick), .txBit(txBit), .rdData(rdData), .ackErr(ackErr),
    .lineClash(lineClash)
  );

  assign protoInd = busy ? modeLs : 1'b1;

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclOe && !sdaOe);  // R10
endmodule

// File: tb/dual_serial_master_test.sv
`timescale 1ns/1ps
module dual_serial_master_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrite = 1'b0, cfgLowSpeed = 1'b0, cmdStart = 1'b0, cmdRead = 1'b0;
  logic [3:0] cfgDivider = '0;
  logic [4:0] cmdDev = '0, cmdReg = '0;
  logic [15:0] cmdWdata = '0;
  logic sclOe, sdaOe, protoInd, busy, done, ackErr, lineClash;
  logic [15:0] rdData;
  logic slavePull = 1'b0;
  logic sclLine, sdaLine;

  assign sclLine = !sclOe;
  assign sdaLine = !(sdaOe || slavePull);

  dual_serial_master #(.PRE_LEN(32), .DIV_W(4)) uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgLowSpeed(cfgLowSpeed),
    .cfgDivider(cfgDivider), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cmdDev(cmdDev), .cmdReg(cmdReg), .cmdWdata(cmdWdata), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .protoInd(protoInd), .busy(busy), .done(done),
    .rdData(rdData), .ackErr(ackErr), .lineClash(lineClash)
  );

  always #5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  int riseCnt = 0, startCnt = 0, stopCnt = 0, periodBad = 0, lastRise = 0, expPeriod = 4;
  logic expLine [0:79];
  logic pullAt  [0:79];
  logic gotLine [0:79];

  always @(posedge clk) cyc++;

  always @(posedge sclLine) begin
    if (riseCnt < 80) gotLine[riseCnt] = sdaLine;
    if (riseCnt > 0 && (cyc - lastRise) != expPeriod) periodBad++;
    lastRise = cyc;
    riseCnt++;
  end
  always @(negedge sclLine) slavePull = (riseCnt < 80) ? pullAt[riseCnt] : 1'b0;
  always @(negedge sdaLine) if (sclLine) startCnt++;
  always @(posedge sdaLine) if (sclLine) stopCnt++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runXfer(input bit ls, input bit rd, input logic [4:0] dev,
                         input logic [4:0] rg, input logic [15:0] wd, input int div,
                         input logic [15:0] sd, input logic [2:0] nack,
                         input int clashIdx, input int injectAt);
    logic [63:0] mf;
    logic [26:0] lf;
    logic m;
    int n, waited, doneCnt, protoBad, mism;
    bit finished, expAck;
    logic [15:0] expRd;
    mf = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, dev, rg, rd ? 2'b11 : 2'b10,
          rd ? 16'hFFFF : wd};
    lf = {dev, 2'b00, rd, 1'b1, 3'b000, rg, 1'b1, rd ? 8'hFF : wd[7:0], 1'b1};
    n = ls ? 27 : 64;
    for (int i = 0; i < 80; i++) pullAt[i] = 1'b0;
    if (ls) begin
      pullAt[8]  = !nack[0];
      pullAt[17] = !nack[1];
      pullAt[26] = !rd && !nack[2];
      if (rd) for (int i = 18; i <= 25; i++) pullAt[i] = !sd[25 - i];
    end else if (rd) begin
      pullAt[47] = 1'b1;
      for (int i = 48; i < 64; i++) pullAt[i] = !sd[63 - i];
    end
    if (clashIdx >= 0) pullAt[clashIdx] = 1'b1;
    for (int i = 0; i < n; i++) begin
      m = ls ? lf[26 - i] : mf[63 - i];
      expLine[i] = m && !pullAt[i];
    end
    expRd  = rd ? (ls ? {8'h00, sd[7:0]} : sd) : 16'h0000;
    expAck = ls && (nack[0] || nack[1] || (!rd && nack[2]));

    @(negedge clk);
    cfgWrite = 1'b1; cfgLowSpeed = ls; cfgDivider = div[3:0];
    @(negedge clk);
    cfgWrite = 1'b0;
    riseCnt = 0; startCnt = 0; stopCnt = 0; periodBad = 0;
    expPeriod = 4 * (div + 1); slavePull = 1'b0;
    cmdStart = 1'b1; cmdRead = rd; cmdDev = dev; cmdReg = rg; cmdWdata = wd;
    @(negedge clk);
    cmdStart = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    waited = 0; finished = 0; doneCnt = 0; protoBad = 0;
    while (!finished && waited < 6000) begin
      if (busy && protoInd != ls) protoBad++;
      if (done) begin doneCnt++; finished = 1; end
      if (waited == injectAt) begin
        cmdStart = 1'b1; cmdRead = !rd; cmdDev = ~dev;
      end else cmdStart = 1'b0;
      @(negedge clk);
      waited++;
    end
    cmdStart = 1'b0;
    repeat (3) begin
      if (done) doneCnt++;
      @(negedge clk);
    end
    slavePull = 1'b0;
    chk(doneCnt == 1, "R9 single done pulse", doneCnt, 1);
    chk(protoBad == 0, "R1 protocol indicator while busy", protoBad, 0);
    chk(protoInd == 1'b1, "R1 indicator idle", protoInd, 1);
    chk(riseCnt == n + (ls ? 1 : 0), ls ? "R5 clock rise count" : "R3 clock rise count",
        riseCnt, n + (ls ? 1 : 0));
    mism = 0;
    for (int i = 0; i < n; i++) if (gotLine[i] !== expLine[i]) mism++;
    chk(mism == 0, ls ? "R5 frame bits" : "R3 frame bits", mism, 0);
    chk(periodBad == 0, "R2 bit period", periodBad, 0);
    chk(rdData == expRd, ls ? "R6 read data" : "R4 read data", rdData, expRd);
    chk(ackErr == expAck, "R7 ack error flag", ackErr, expAck);
    chk(lineClash == (clashIdx >= 0), "R8 line clash flag", lineClash, clashIdx >= 0);
    chk(!sclOe && !sdaOe, "R10 lines released after done", {sclOe, sdaOe}, 0);
    if (ls) begin
      chk(startCnt == 1, "R10 start condition count", startCnt, 1);
      chk(stopCnt == 1, "R10 stop condition count", stopCnt, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R9 reset handshake", {busy, done}, 0);
    chk(!sclOe && !sdaOe, "R10 reset lines", {sclOe, sdaOe}, 0);
    chk(protoInd == 1'b1, "R1 reset indicator", protoInd, 1);
    chk(rdData == 16'h0 && !ackErr && !lineClash, "R7 reset status",
        {rdData, ackErr, lineClash}, 0);

    // management writes over dividers and field patterns
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 3; k++)
        runXfer(1'b0, 1'b0, 5'((k * 7 + d) % 32), 5'((k * 11 + 3 * d) % 32),
                16'((16'hA5C3 << k) ^ (16'h1111 * d)), d, 16'h0, 3'b000, -1, -1);
    // management reads
    for (int k = 0; k < 4; k++)
      runXfer(1'b0, 1'b1, 5'(k * 9 % 32), 5'(31 - k), 16'h0, k % 2,
              16'((16'h8001 * (k + 1)) ^ 16'h3C5A), 3'b000, -1, -1);
    // byte protocol writes over every missing-ack pattern (R7)
    for (int m = 0; m < 8; m++)
      runXfer(1'b1, 1'b0, 5'(m * 5 % 32), 5'(m * 3), 16'(8'h5A + m * 17), 1,
              16'h0, 3'(m), -1, -1);
    // byte protocol reads (R6)
    for (int k = 0; k < 3; k++)
      runXfer(1'b1, 1'b1, 5'(k + 2), 5'(k * 6), 16'h0, k,
              16'(8'hC3 ^ (k * 8'h29)), 3'b000, -1, -1);
    runXfer(1'b1, 1'b1, 5'h04, 5'h01, 16'h0, 0, 16'h0096, 3'b001, -1, -1);
    // conflicts where the master releases the line (R8)
    runXfer(1'b0, 1'b0, 5'h03, 5'h07, 16'hFFFF, 0, 16'h0, 3'b000, 5, -1);
    runXfer(1'b1, 1'b0, 5'h10, 5'h02, 16'h00F0, 0, 16'h0, 3'b000, 0, -1);
    // start request while busy is ignored (R9)
    runXfer(1'b0, 1'b0, 5'h15, 5'h0A, 16'h1234, 1, 16'h0, 3'b000, -1, 100);
    runXfer(1'b1, 1'b0, 5'h0B, 5'h1C, 16'h00A7, 1, 16'h0, 3'b000, -1, 60);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule